// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, given as a byte start address and a byte length, into a run of erase commands for a page-organised serial flash. The device is driven through a byte-wide SPI exchange port. Each step erases either one page or an aligned group of eight pages. After each command the block polls the device status until it reports ready, and only then moves to the next step.

Page size, the address shift applied to a page index, the device size and the spacing between status polls are configuration inputs. The block uses one shared sequential divider to turn the byte address and the byte length into a page index and a page count. It then checks bounds and alignment before it issues any traffic.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start plus length is greater than `cfg_dev_size` ends with `req_err` and `req_done` high in the same cycle, and no SPI byte is exchanged.
- R2: A request whose start or length is not a whole multiple of `cfg_page_size`, or any request while `cfg_page_size` is zero, ends with `req_err` and `req_done` and no SPI byte.
- R3: A step uses opcode 0x50 (eight-page erase) when the current page index has bits 2..0 at zero and at least eight pages remain. Otherwise it uses opcode 0x81 (single-page erase).
- R4: Each erase command is one chip-select frame (`spi_cs_n` low) of exactly four bytes: the opcode, then bits 23..16 of (page index shifted left by `cfg_page_shift`), then bits 15..8 of that value, then 0x00. `spi_cs_n` is high between frames.
- R5: After each erase command the block polls status in frames of two bytes, 0xD7 and then 0x00. The byte received during the second byte is the status. Polling repeats until status bit 7 is 1.
- R6: Before every status poll frame, `spi_cs_n` stays high for at least `cfg_poll_gap` cycles.
- R7: After an eight-page erase the page index advances by eight and the page count falls by eight. After a single-page erase both change by one. The sequence covers each requested page exactly once.
- R8: `req_done` is a one-cycle pulse after the final step. A zero-length aligned request completes with `req_done`, no `req_err` and no SPI traffic. After reset `spi_cs_n` is high and `req_done` is low.
- R9: `req_start` is ignored while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start pulse for a request |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | ADDR_W | Byte length |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request rejected (with req_done) |
| cfg_page_size | input | ADDR_W | Page size in bytes |
| cfg_page_shift | input | SHIFT_W | Left shift applied to a page index |
| cfg_dev_size | input | ADDR_W | Device size in bytes |
| cfg_poll_gap | input | GAP_W | Minimum idle cycles before a status poll |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_req | output | 1 | Byte exchange request, held until ack |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte received, valid with ack |

## Verification
The bench builds the block with a 24-bit address, so a shift of 11 on page indexes near 4000 drives nonzero values into the top address byte. It also uses a 4-bit shift field and an 8-bit poll-gap counter, which lets it try a zero gap and a gap of several cycles. Page sizes of 264 and 1056 bytes exercise the divider with divisors that are not powers of two. A device model that stays busy for two polls after each erase shows that the block really loops on the ready bit.

// File: rtl/fes_pkg.sv
package fes_pkg;
    localparam logic [7:0] OP_ERASE_PAGE  = 8'h81;
    localparam logic [7:0] OP_ERASE_GROUP = 8'h50;
    localparam logic [7:0] OP_STATUS      = 8'hD7;
    localparam logic [7:0] FILL_BYTE      = 8'h00;
    localparam int GROUP_PAGES = 8;
    localparam int READY_BIT   = 7;

    typedef enum logic [3:0] {
        S_IDLE, S_DIV_ADDR, S_DIV_LEN, S_CHECK,
        S_CMD, S_GAP, S_POLL_OP, S_POLL_RD, S_STEP
    } seq_state_e;

    function automatic logic [7:0] pick_opcode(input logic group);
        return group ? OP_ERASE_GROUP : OP_ERASE_PAGE;
    endfunction
endpackage

// File: rtl/fes_divider.sv
module fes_divider #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic [W-1:0]  q_r, r_r, dvs_r, dvd_r;
    logic [W:0]    trial;
    logic          fits;

    assign trial = {r_r, q_r[W-1]};
    assign fits  = trial >= {1'b0, dvs_r};
    assign quot  = q_r;
    assign rem   = r_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            valid <= 1'b0;
            q_r   <= '0;
            r_r   <= '0;
            dvs_r <= '0;
            dvd_r <= '0;
        end else begin
            valid <= 1'b0;
            if (start) begin
                r_r   <= '0;
                q_r   <= dividend;
                dvd_r <= dividend;
                dvs_r <= divisor;
                cnt   <= CW'(W);
            end else if (cnt != '0) begin
                r_r   <= fits ? W'(trial - {1'b0, dvs_r}) : trial[W-1:0];
                q_r   <= {q_r[W-2:0], fits};
                cnt   <= cnt - 1'b1;
                valid <= (cnt == CW'(1));
            end
        end
    end

    assert_div_exact_R2: assert property (@(posedge clk) disable iff (rst)
        (valid && dvs_r != '0) |->
        ((2*W)'(q_r) * (2*W)'(dvs_r) + (2*W)'(r_r) == (2*W)'(dvd_r)));
    assert_div_rem_small_R2: assert property (@(posedge clk) disable iff (rst)
        (valid && dvs_r != '0) |-> (r_r < dvs_r));
endmodule

// File: rtl/fes_cmd_fmt.sv
module fes_cmd_fmt #(
    parameter int W       = 24,
    parameter int SHIFT_W = 4
) (
    input  logic [W-1:0]       page_idx,
    input  logic [W-1:0]       pages_left,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [1:0]         sel,
    output logic               use_group,
    output logic [7:0]         cmd_byte
);
    import fes_pkg::*;
    localparam int EW = W + (1 << SHIFT_W);

    logic [15:0] addr_mid;

    assign use_group = (page_idx[2:0] == 3'b000) && (pages_left >= W'(GROUP_PAGES));
    assign addr_mid  = 16'((EW'(page_idx) << shift) >> 8);

    always_comb begin
        case (sel)
            2'd0:    cmd_byte = pick_opcode(use_group);
            2'd1:    cmd_byte = addr_mid[15:8];
            2'd2:    cmd_byte = addr_mid[7:0];
            default: cmd_byte = FILL_BYTE;
        endcase
    end
endmodule

// File: rtl/fes_gap_timer.sv
module fes_gap_timer #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    output logic          expired
);
    logic [GW-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (load)          cnt <= load_val;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assert_gap_countdown_R6: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter int ADDR_W  = 24,
    parameter int SHIFT_W = 4,
    parameter int GAP_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_start,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [ADDR_W-1:0]  req_len,
    output logic               req_done,
    output logic               req_err,
    input  logic [ADDR_W-1:0]  cfg_page_size,
    input  logic [SHIFT_W-1:0] cfg_page_shift,
    input  logic [ADDR_W-1:0]  cfg_dev_size,
    input  logic [GAP_W-1:0]   cfg_poll_gap,
    output logic               spi_cs_n,
    output logic               spi_req,
    output logic [7:0]         spi_tx,
    input  logic               spi_ack,
    input  logic [7:0]         spi_rx
);
    import fes_pkg::*;

    seq_state_e        state;
    logic [ADDR_W-1:0] addr_r, len_r, page_idx, pages_left, rem_a, rem_l;
    logic [1:0]        byte_sel;
    logic              div_start, div_valid, use_group, gap_load, gap_expired;
    logic [ADDR_W-1:0] div_dvd, div_q, div_r, step_pages, left_next;
    logic [7:0]        cmd_byte;
    logic              bad_req;

    assign div_start = (state == S_IDLE && req_start) || (state == S_DIV_ADDR && div_valid);
    assign div_dvd   = (state == S_IDLE) ? req_addr : len_r;

    fes_divider #(.W(ADDR_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .dividend(div_dvd),
        .divisor(cfg_page_size), .valid(div_valid), .quot(div_q), .rem(div_r)
    );

    fes_cmd_fmt #(.W(ADDR_W), .SHIFT_W(SHIFT_W)) u_fmt (
        .page_idx(page_idx), .pages_left(pages_left), .shift(cfg_page_shift),
        .sel(byte_sel), .use_group(use_group), .cmd_byte(cmd_byte)
    );

    assign gap_load = (state == S_CMD && spi_ack && byte_sel == 2'd3) ||
                      (state == S_POLL_RD && spi_ack && !spi_rx[READY_BIT]);

    fes_gap_timer #(.GW(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(cfg_poll_gap),
        .expired(gap_expired)
    );

    assign bad_req = ({1'b0, addr_r} + {1'b0, len_r} > {1'b0, cfg_dev_size}) ||
                     (cfg_page_size == '0) || (rem_a != '0) || (rem_l != '0);
    assign step_pages = use_group ? ADDR_W'(GROUP_PAGES) : ADDR_W'(1);
    assign left_next  = pages_left - step_pages;

    assign spi_req = (state == S_CMD) || (state == S_POLL_OP) || (state == S_POLL_RD);
    always_comb begin
        case (state)
            S_CMD:     spi_tx = cmd_byte;
            S_POLL_OP: spi_tx = OP_STATUS;
            default:   spi_tx = FILL_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            addr_r     <= '0;
            len_r      <= '0;
            page_idx   <= '0;
            pages_left <= '0;
            rem_a      <= '0;
            rem_l      <= '0;
            byte_sel   <= '0;
            spi_cs_n   <= 1'b1;
            req_done   <= 1'b0;
            req_err    <= 1'b0;
        end else begin
            req_done <= 1'b0;
            req_err  <= 1'b0;
            case (state)
                S_IDLE: if (req_start) begin
                    addr_r <= req_addr;
                    len_r  <= req_len;
                    state  <= S_DIV_ADDR;
                end
                S_DIV_ADDR: if (div_valid) begin
                    page_idx <= div_q;
                    rem_a    <= div_r;
                    state    <= S_DIV_LEN;
                end
                S_DIV_LEN: if (div_valid) begin
                    pages_left <= div_q;
                    rem_l      <= div_r;
                    state      <= S_CHECK;
                end
                S_CHECK: begin
                    if (bad_req || pages_left == '0) begin
                        req_done <= 1'b1;
                        req_err  <= bad_req;
                        state    <= S_IDLE;
                    end else begin
                        spi_cs_n <= 1'b0;
                        byte_sel <= '0;
                        state    <= S_CMD;
                    end
                end
                S_CMD: if (spi_ack) begin
                    if (byte_sel == 2'd3) begin
                        spi_cs_n <= 1'b1;
                        state    <= S_GAP;
                    end else begin
                        byte_sel <= byte_sel + 1'b1;
                    end
                end
                S_GAP: if (gap_expired) begin
                    spi_cs_n <= 1'b0;
                    state    <= S_POLL_OP;
                end
                S_POLL_OP: if (spi_ack) state <= S_POLL_RD;
                S_POLL_RD: if (spi_ack) begin
                    spi_cs_n <= 1'b1;
                    state    <= spi_rx[READY_BIT] ? S_STEP : S_GAP;
                end
                S_STEP: begin
                    page_idx   <= page_idx + step_pages;
                    pages_left <= left_next;
                    if (left_next == '0) begin
                        req_done <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        spi_cs_n <= 1'b0;
                        byte_sel <= '0;
                        state    <= S_CMD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_cs_framed_R4: assert property (@(posedge clk) disable iff (rst)
        spi_req |-> !spi_cs_n);
    assert_byte_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
    assert_err_with_done_R1: assert property (@(posedge clk) disable iff (rst)
        req_err |-> req_done);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);
    assert_no_bus_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> (spi_cs_n && !spi_req));
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
    localparam int AW = 24, SW = 4, GW = 8;
    localparam int LAT = 2, BUSY_N = 2, MAXF = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0, req_len = '0;
    logic          req_done, req_err;
    logic [AW-1:0] cfg_page_size = 24'd264, cfg_dev_size = 24'd264 * 64;
    logic [SW-1:0] cfg_page_shift = 4'd9;
    logic [GW-1:0] cfg_poll_gap = 8'd3;
    logic          spi_cs_n, spi_req, spi_ack;
    logic [7:0]    spi_tx, spi_rx;

    flash_erase_seq #(.ADDR_W(AW), .SHIFT_W(SW), .GAP_W(GW)) u0 (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_len(req_len), .req_done(req_done), .req_err(req_err),
        .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
        .cfg_dev_size(cfg_dev_size), .cfg_poll_gap(cfg_poll_gap),
        .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
        .spi_ack(spi_ack), .spi_rx(spi_rx)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // Device model: records frames, answers status polls
    logic       clr = 1'b0;
    logic [7:0] fb [MAXF][4];
    int         flen [MAXF];
    int         fgap [MAXF];
    int         nfr, cur_len, hi_cnt, busy_left, dly, n_done;
    logic       cs_q, pend, last_err;

    always @(posedge clk) begin
        spi_ack <= 1'b0;
        if (rst || clr) begin
            pend <= 1'b0; cs_q <= 1'b1; hi_cnt <= 0; busy_left <= 0;
            nfr <= 0; cur_len <= 0; dly <= 0; spi_rx <= 8'h00;
            n_done <= 0; last_err <= 1'b0;
        end else begin
            cs_q <= spi_cs_n;
            if (req_done) begin n_done <= n_done + 1; last_err <= req_err; end
            hi_cnt <= spi_cs_n ? hi_cnt + 1 : 0;
            if (!spi_cs_n && cs_q) begin fgap[nfr] <= hi_cnt; cur_len <= 0; end
            if (spi_cs_n && !cs_q) begin
                flen[nfr] <= cur_len;
                nfr <= nfr + 1;
                if (fb[nfr][0] == 8'h81 || fb[nfr][0] == 8'h50) busy_left <= BUSY_N;
            end
            if (pend) begin
                if (dly == 0) begin
                    spi_ack <= 1'b1;
                    pend <= 1'b0;
                    if (cur_len < 4) fb[nfr][cur_len] <= spi_tx;
                    cur_len <= cur_len + 1;
                    if (cur_len == 1 && fb[nfr][0] == 8'hD7) begin
                        spi_rx <= (busy_left > 0) ? 8'h1C : 8'h9C;
                        if (busy_left > 0) busy_left <= busy_left - 1;
                    end else spi_rx <= 8'h00;
                end else dly <= dly - 1;
            end else if (spi_req && !spi_ack) begin
                pend <= 1'b1;
                dly <= LAT;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [AW-1:0] a, input logic [AW-1:0] l, input bit poke);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        req_addr = a; req_len = l; req_start = 1'b1;
        @(negedge clk) req_start = 1'b0;
        for (int i = 0; i < 40000 && n_done == 0; i++) begin
            @(negedge clk);
            if (poke && i == 200) begin
                req_addr = 24'd1; req_len = 24'd3; req_start = 1'b1;
            end else req_start = 1'b0;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic verify_frames(input int pg, input int cnt);
        int f = 0;
        int idx = pg;
        int left = cnt;
        while (left > 0) begin
            bit grp = (idx % 8 == 0) && (left >= 8);
            logic [23:0] a = 24'(idx << cfg_page_shift);
            logic [7:0] op = grp ? 8'h50 : 8'h81;
            check(f < nfr && flen[f] == 4, "R4", "cmd frame length", flen[f], 4);
            check(fb[f][0] == op, "R3", "opcode", fb[f][0], op);
            check(fb[f][1] == a[23:16] && fb[f][2] == a[15:8] && fb[f][3] == 8'h00,
                  "R4", "address bytes", {fb[f][1], fb[f][2], fb[f][3]}, {a[23:8], 8'h00});
            f++;
            for (int p = 0; p <= BUSY_N; p++) begin
                check(flen[f] == 2 && fb[f][0] == 8'hD7 && fb[f][1] == 8'h00,
                      "R5", "poll frame", {fb[f][0], fb[f][1]}, 16'hD700);
                check(fgap[f] >= int'(cfg_poll_gap), "R6", "poll gap", fgap[f], cfg_poll_gap);
                f++;
            end
            idx += grp ? 8 : 1;
            left -= grp ? 8 : 1;
        end
        check(nfr == f, "R7", "frame count", nfr, f);
        check(n_done == 1 && last_err == 1'b0, "R8", "done once without err", n_done, 1);
    endtask

    task automatic t_reset;
        check(spi_cs_n == 1'b1 && spi_req == 1'b0, "R4", "bus idle after reset", spi_cs_n, 1);
        check(req_done == 1'b0 && req_err == 1'b0, "R8", "no done after reset", req_done, 0);
    endtask

    task automatic t_bounds;
        run_req(24'd60 * 264, 24'd5 * 264, 0);
        check(n_done == 1 && last_err, "R1", "overflow rejected", last_err, 1);
        check(nfr == 0, "R1", "no traffic on overflow", nfr, 0);
        run_req(24'd56 * 264, 24'd8 * 264, 0);
        verify_frames(56, 8);
    endtask

    task automatic t_align;
        run_req(24'd265, 24'd264, 0);
        check(last_err && nfr == 0, "R2", "misaligned start", nfr, 0);
        run_req(24'd264, 24'd263, 0);
        check(last_err && nfr == 0, "R2", "misaligned length", nfr, 0);
        cfg_page_size = '0;
        run_req(24'd0, 24'd0, 0);
        check(last_err && n_done == 1 && nfr == 0, "R2", "zero page size", last_err, 1);
        cfg_page_size = 24'd264;
    endtask

    task automatic t_zero_len;
        run_req(24'd3 * 264, 24'd0, 0);
        check(n_done == 1 && !last_err && nfr == 0, "R8", "empty request", nfr, 0);
    endtask

    task automatic t_mixed;
        run_req(24'd6 * 264, 24'd12 * 264, 1);  // start pulse mid-run for R9
        verify_frames(6, 12);
        check(n_done == 1, "R9", "start ignored while busy", n_done, 1);
    endtask

    task automatic t_short_aligned;
        run_req(24'd0, 24'd7 * 264, 0);
        verify_frames(0, 7);
    endtask

    task automatic t_high_addr;
        cfg_page_size = 24'd1056; cfg_page_shift = 4'd11;
        cfg_dev_size = 24'd1056 * 8192; cfg_poll_gap = 8'd0;
        run_req(24'd4000 * 1056, 24'd9 * 1056, 0);
        verify_frames(4000, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_align();
        t_zero_len();
        t_mixed();
        t_short_aligned();
        t_high_addr();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule